// File: doc/BRIEF.md
# Clock Synthesizer Programming Sequencer

This block brings a clock synthesizer from an unknown setting to a new one without software help. It is started with a reference divider N, a feedback multiplier M, four optional post-divider ratios and the internal reference frequency in kHz. It then drives a single-outstanding register master port. It writes the two divider words, read-modify-writes the control word so that every output is bypassed and gated, and writes 1 to the commit register.

It polls until the commit bit falls and then until the lock flag rises. Only after that does it rewrite the control word to ungate the requested outputs and take them out of bypass. Last, it polls the status word until every requested output acknowledges. The sequence ends with `done_o`, or with `err_o` and a code that names the step that failed. A failure stops the sequence at once, and the outputs stay gated.

Each bit wait starts with a burst of back-to-back reads. The commit and lock waits then fall back to one read per slow interval until a cycle budget is spent. The acknowledge wait gives up after its burst alone.

Top module: `clksyn_cfg_seq`

## Requirements
- R1: The divider word is written to offset 0x0C. It holds N−1 in bits 8:1, M in bits 20:9, the first output code in bits 25:21 and the second output code in bits 30:26. Bits 0 and 31 are zero. An output code is ratio−1, or 0 when the ratio is 0, which means the output is unused.
- R2: The second divider word is written to offset 0x14. It holds the third output code in bits 4:0 and the fourth output code in bits 9:5. All other bits are zero.
- R3: The reference-range field, bits 4:1 of the control word at 0x10, is 3 below 1000 kHz, 4 below 1250 kHz, 5 below 1500 kHz, 6 below 1750 kHz and 7 at or above 1750 kHz.
- R4: The first control-word write keeps every bit read from 0x10 except the following. It sets bit 13 (reference enable) and bit 20 (bypass). It clears bit 14 (clock input enable) and output enables 16, 18, 23 and 25.
- R5: Before any polling, the writes go in this order: 0x0C, 0x14, 0x10, then the value 1 to the commit register 0x08. A successful run makes exactly five writes, the fifth to 0x10.
- R6: After the commit write, the block polls 0x08 until bit 0 reads 0, then polls status 0x04 until bit 1 (lock) reads 1. The output-enable write happens only after lock has been seen.
- R7: The second control-word write re-reads 0x10. It sets bit 14, clears bit 20, and sets enable bit 16, 18, 23 or 25 only for outputs one to four whose ratio is nonzero.
- R8: The block then polls status until acknowledge bits 7, 8, 10 and 11 are all set for the enabled outputs, and raises `done_o`. A hit on the 100th read still succeeds. If 100 reads all miss, the block ends with error code 3. When no output is enabled, the first read completes the run.
- R9: The commit and lock waits make 100 back-to-back reads, then one read per SLOW_GAP cycles, until TIMEOUT_CYC cycles have passed since the wait began. A stuck commit bit gives code 1 and a missing lock gives code 2. No output-enable write follows an error.
- R10: A request holds its address, direction and data stable until the cycle in which `bus_ack_i` is high.
- R11: After reset the block is idle, with no request and with `done_o` and `err_o` low. `done_o` and `err_o` are never high together and hold until the next start. A start pulse while the block is busy is ignored. Error codes: 0 none, 1 commit stuck, 2 no lock, 3 acknowledge timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| n_i | input | 8 | Reference divider N |
| m_i | input | 12 | Feedback multiplier M |
| div_i | input | 20 | Four 5-bit output ratios, first output in bits 4:0 |
| fint_khz_i | input | 16 | Internal reference frequency in kHz |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 8 | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Sequence aborted |
| err_code_o | output | 2 | Failure point code |

## Verification
The sharpest same-cycle collision is between the acknowledge arriving and the read budget running out. Both can land on one status read, and the block must call that read a success. The bench model withholds acknowledges until a chosen read number. A run that releases them on read 100 must end in `done_o`. A run that releases them on read 101 must end in error code 3. A second collision comes from a start pulse that lands while a sequence is running. The bench counts commit writes to show that the pulse did not restart the sequence.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  localparam logic [7:0] A_STAT   = 8'h04;
  localparam logic [7:0] A_COMMIT = 8'h08;
  localparam logic [7:0] A_CFG1   = 8'h0C;
  localparam logic [7:0] A_CFG2   = 8'h10;
  localparam logic [7:0] A_CFG3   = 8'h14;

  localparam int NUM_OUT   = 4;
  localparam int SEL_LSB   = 1;
  localparam int REFEN_POS = 13;
  localparam int CLKIN_POS = 14;
  localparam int BYP_POS   = 20;
  localparam int EN_POS  [NUM_OUT] = '{16, 18, 23, 25};
  localparam int ACK_POS [NUM_OUT] = '{7, 8, 10, 11};

  typedef enum logic [3:0] {
    S_IDLE, S_W_CFG1, S_W_CFG3, S_R_CFG2A, S_W_CFG2A, S_W_GO,
    S_P_GO, S_P_LOCK, S_R_CFG2B, S_W_CFG2B, S_P_ACK
  } seq_state_t;

  typedef enum logic [1:0] {E_NONE, E_COMMIT, E_LOCK, E_ACK} seq_err_t;

  // Reference-range code from the internal reference frequency in kHz
  function automatic logic [3:0] ref_range(input logic [15:0] khz);
    if (khz < 16'd1000)      return 4'd3;
    else if (khz < 16'd1250) return 4'd4;
    else if (khz < 16'd1500) return 4'd5;
    else if (khz < 16'd1750) return 4'd6;
    else                     return 4'd7;
  endfunction

endpackage

// File: rtl/clksyn_word_build.sv
module clksyn_word_build
  import clksyn_pkg::*;
#(
  parameter int N_W  = 8,
  parameter int M_W  = 12,
  parameter int HD_W = 5
) (
  input  logic [N_W-1:0]          n_i,
  input  logic [M_W-1:0]          m_i,
  input  logic [NUM_OUT*HD_W-1:0] div_i,
  input  logic [15:0]             fint_khz_i,
  input  logic [31:0]             cfg2_rd_i,
  output logic [31:0]             cfg1_o,
  output logic [31:0]             cfg3_o,
  output logic [31:0]             cfg2_pre_o,
  output logic [31:0]             cfg2_en_o,
  output logic [31:0]             ack_mask_o
);
  localparam int N_LSB = 1;
  localparam int M_LSB = N_LSB + N_W;
  localparam int D_LSB = M_LSB + M_W;

  function automatic logic [HD_W-1:0] div_code(input logic [HD_W-1:0] v);
    return (v == '0) ? '0 : v - HD_W'(1);
  endfunction

  logic [HD_W-1:0]    code [NUM_OUT];
  logic [NUM_OUT-1:0] used;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    assign code[g] = div_code(div_i[g*HD_W +: HD_W]);
    assign used[g] = |div_i[g*HD_W +: HD_W];
  end

  always_comb begin
    cfg1_o = '0;
    cfg1_o[N_LSB +: N_W]        = n_i - N_W'(1);
    cfg1_o[M_LSB +: M_W]        = m_i;
    cfg1_o[D_LSB +: HD_W]       = code[0];
    cfg1_o[D_LSB+HD_W +: HD_W]  = code[1];

    cfg3_o = '0;
    cfg3_o[0 +: HD_W]    = code[2];
    cfg3_o[HD_W +: HD_W] = code[3];

    cfg2_pre_o = cfg2_rd_i;
    cfg2_pre_o[SEL_LSB +: 4] = ref_range(fint_khz_i);
    cfg2_pre_o[REFEN_POS]    = 1'b1;
    cfg2_pre_o[BYP_POS]      = 1'b1;
    cfg2_pre_o[CLKIN_POS]    = 1'b0;

    cfg2_en_o = cfg2_rd_i;
    cfg2_en_o[CLKIN_POS] = 1'b1;
    cfg2_en_o[BYP_POS]   = 1'b0;

    ack_mask_o = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      cfg2_pre_o[EN_POS[i]]  = 1'b0;
      cfg2_en_o[EN_POS[i]]   = used[i];
      ack_mask_o[ACK_POS[i]] = used[i];
    end
  end

endmodule

// File: rtl/clksyn_poll.sv
module clksyn_poll #(
  parameter int FAST_POLLS  = 100,
  parameter int SLOW_GAP    = 50,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sample,
  input  logic hit,
  input  logic slow_en,
  output logic may_issue,
  output logic give_up
);
  localparam int CW = $clog2(FAST_POLLS + 1);
  localparam int GW = $clog2(SLOW_GAP + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gap_q;
  logic [TW-1:0] el_q;
  logic          miss, burst_spent, tmo_reached;

  assign miss        = sample && !hit;
  assign burst_spent = (int'(cnt_q) + 1) >= FAST_POLLS;
  assign tmo_reached = int'(el_q) >= TIMEOUT_CYC;
  assign give_up     = miss && burst_spent && (!slow_en || tmo_reached);
  assign may_issue   = (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= '0;
      el_q  <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      gap_q <= '0;
      el_q  <= '0;
    end else begin
      if (!tmo_reached) el_q <= el_q + TW'(1);
      if (miss) begin
        if (!burst_spent) cnt_q <= cnt_q + CW'(1);
        gap_q <= (burst_spent && slow_en) ? GW'(SLOW_GAP) : '0;
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
      end
    end
  end

endmodule

// File: rtl/clksyn_cfg_seq.sv
module clksyn_cfg_seq
  import clksyn_pkg::*;
#(
  parameter int N_W         = 8,
  parameter int M_W         = 12,
  parameter int HD_W        = 5,
  parameter int FAST_POLLS  = 100,
  parameter int SLOW_GAP    = 50,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [N_W-1:0]          n_i,
  input  logic [M_W-1:0]          m_i,
  input  logic [4*HD_W-1:0]       div_i,
  input  logic [15:0]             fint_khz_i,
  output logic                    bus_req_o,
  output logic                    bus_we_o,
  output logic [7:0]              bus_addr_o,
  output logic [31:0]             bus_wdata_o,
  input  logic [31:0]             bus_rdata_i,
  input  logic                    bus_ack_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic [1:0]              err_code_o
);
  seq_state_t state_q, state_d;
  seq_err_t   code_q;

  logic [N_W-1:0]    n_q;
  logic [M_W-1:0]    m_q;
  logic [4*HD_W-1:0] div_q;
  logic [15:0]       fint_q;
  logic [31:0]       cfg2_q;
  logic [31:0]       w_cfg1, w_cfg3, w_pre, w_en, ack_mask;
  logic              done_q, err_q;

  logic is_poll, poll_hit, poll_sample, poll_restart, poll_issue, poll_giveup;
  logic slow_en;
  // Named events for the checker
  logic ev_commit_wr, ev_enable_wr, ev_lock_seen;

  clksyn_word_build #(.N_W(N_W), .M_W(M_W), .HD_W(HD_W)) u_words (
    .n_i(n_q), .m_i(m_q), .div_i(div_q), .fint_khz_i(fint_q),
    .cfg2_rd_i(cfg2_q),
    .cfg1_o(w_cfg1), .cfg3_o(w_cfg3), .cfg2_pre_o(w_pre),
    .cfg2_en_o(w_en), .ack_mask_o(ack_mask)
  );

  clksyn_poll #(.FAST_POLLS(FAST_POLLS), .SLOW_GAP(SLOW_GAP),
                .TIMEOUT_CYC(TIMEOUT_CYC)) u_poll (
    .clk(clk), .rst_n(rst_n), .restart(poll_restart), .sample(poll_sample),
    .hit(poll_hit), .slow_en(slow_en), .may_issue(poll_issue),
    .give_up(poll_giveup)
  );

  assign is_poll      = (state_q == S_P_GO) || (state_q == S_P_LOCK) ||
                        (state_q == S_P_ACK);
  assign poll_sample  = is_poll && bus_ack_i;
  assign slow_en      = (state_q != S_P_ACK);
  assign ev_commit_wr = (state_q == S_W_GO) && bus_ack_i;
  assign ev_enable_wr = (state_q == S_W_CFG2B) && bus_ack_i;
  assign poll_restart = ev_commit_wr || ev_enable_wr ||
                        ((state_q == S_P_GO) && poll_sample && poll_hit);

  always_comb begin
    unique case (state_q)
      S_P_GO:   poll_hit = !bus_rdata_i[0];
      S_P_LOCK: poll_hit = bus_rdata_i[1];
      S_P_ACK:  poll_hit = ((bus_rdata_i & ack_mask) == ack_mask);
      default:  poll_hit = 1'b0;
    endcase
  end

  // Register port drive
  always_comb begin
    bus_we_o    = 1'b0;
    bus_addr_o  = A_STAT;
    bus_wdata_o = '0;
    unique case (state_q)
      S_W_CFG1:  begin bus_we_o = 1'b1; bus_addr_o = A_CFG1; bus_wdata_o = w_cfg1; end
      S_W_CFG3:  begin bus_we_o = 1'b1; bus_addr_o = A_CFG3; bus_wdata_o = w_cfg3; end
      S_W_CFG2A: begin bus_we_o = 1'b1; bus_addr_o = A_CFG2; bus_wdata_o = w_pre;  end
      S_W_CFG2B: begin bus_we_o = 1'b1; bus_addr_o = A_CFG2; bus_wdata_o = w_en;   end
      S_W_GO:    begin bus_we_o = 1'b1; bus_addr_o = A_COMMIT; bus_wdata_o = 32'd1; end
      S_P_GO:    bus_addr_o = A_COMMIT;
      S_R_CFG2A, S_R_CFG2B: bus_addr_o = A_CFG2;
      default:   ;
    endcase
  end

  assign bus_req_o = (state_q != S_IDLE) && (!is_poll || poll_issue);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i)   state_d = S_W_CFG1;
      S_W_CFG1:  if (bus_ack_i) state_d = S_W_CFG3;
      S_W_CFG3:  if (bus_ack_i) state_d = S_R_CFG2A;
      S_R_CFG2A: if (bus_ack_i) state_d = S_W_CFG2A;
      S_W_CFG2A: if (bus_ack_i) state_d = S_W_GO;
      S_W_GO:    if (bus_ack_i) state_d = S_P_GO;
      S_P_GO:    if (poll_sample && poll_hit) state_d = S_P_LOCK;
                 else if (poll_giveup)       state_d = S_IDLE;
      S_P_LOCK:  if (poll_sample && poll_hit) state_d = S_R_CFG2B;
                 else if (poll_giveup)       state_d = S_IDLE;
      S_R_CFG2B: if (bus_ack_i) state_d = S_W_CFG2B;
      S_W_CFG2B: if (bus_ack_i) state_d = S_P_ACK;
      S_P_ACK:   if ((poll_sample && poll_hit) || poll_giveup) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      code_q       <= E_NONE;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
      n_q          <= '0;
      m_q          <= '0;
      div_q        <= '0;
      fint_q       <= '0;
      cfg2_q       <= '0;
      ev_lock_seen <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        n_q          <= n_i;
        m_q          <= m_i;
        div_q        <= div_i;
        fint_q       <= fint_khz_i;
        done_q       <= 1'b0;
        err_q        <= 1'b0;
        code_q       <= E_NONE;
        ev_lock_seen <= 1'b0;
      end
      if ((state_q == S_R_CFG2A || state_q == S_R_CFG2B) && bus_ack_i)
        cfg2_q <= bus_rdata_i;
      if (state_q == S_P_LOCK && poll_sample && poll_hit)
        ev_lock_seen <= 1'b1;
      if (state_q == S_P_ACK && poll_sample && poll_hit)
        done_q <= 1'b1;
      if (poll_giveup) begin
        err_q <= 1'b1;
        unique case (state_q)
          S_P_GO:   code_q <= E_COMMIT;
          S_P_LOCK: code_q <= E_LOCK;
          default:  code_q <= E_ACK;
        endcase
      end
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

endmodule

// File: rtl/clksyn_cfg_seq_chk.sv
module clksyn_cfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [7:0]  bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic        bus_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        ev_enable_wr,
  input logic        ev_lock_seen
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));
  // R6
  enable_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enable_wr |-> ev_lock_seen);
  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> !bus_req_o);
  // R8
  done_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ev_lock_seen);
endmodule

bind clksyn_cfg_seq clksyn_cfg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ack_i(bus_ack_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .ev_enable_wr(ev_enable_wr), .ev_lock_seen(ev_lock_seen)
);

// File: tb/clksyn_cfg_seq_tb.sv
`timescale 1ns/1ps
module clksyn_cfg_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  n_in = '0;
  logic [11:0] m_in = '0;
  logic [19:0] d_in = '0;
  logic [15:0] f_in = '0;
  logic        bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        busy, done, err;
  logic [1:0]  code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clksyn_cfg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .n_i(n_in), .m_i(m_in),
    .div_i(d_in), .fint_khz_i(f_in), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .busy_o(busy), .done_o(done), .err_o(err),
    .err_code_o(code)
  );

  // ---------------- register responder model ----------------
  int          go_delay, lock_delay, ack_k;
  logic [31:0] cfg2_init;
  logic        model_clr = 1'b1;
  logic [31:0] reg_cfg2, cfg1_v, cfg3_v, cfg2a_v, cfg2b_v, st;
  logic        go_bit, lock_bit, go_run, lock_at_en;
  int          go_t, wr_n, cfg2_wr_n, commit_n, lock_rd, ack_rd;
  logic [7:0]  wr_log [16];

  always @(posedge clk) begin
    if (model_clr) begin
      bus_ack <= 1'b0; bus_rdata <= '0; reg_cfg2 <= cfg2_init;
      go_bit <= 1'b0; lock_bit <= 1'b0; go_run <= 1'b0; lock_at_en <= 1'b0;
      go_t <= 0; wr_n <= 0; cfg2_wr_n <= 0; commit_n <= 0; lock_rd <= 0; ack_rd <= 0;
    end else begin
      if (go_run) go_t <= go_t + 1;
      if (go_run && go_delay >= 0 && go_t == go_delay) go_bit <= 1'b0;
      if (go_run && go_delay >= 0 && lock_delay >= 0 && go_t == go_delay + lock_delay)
        lock_bit <= 1'b1;
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          if (wr_n < 16) wr_log[wr_n] <= bus_addr;
          wr_n <= wr_n + 1;
          case (bus_addr)
            8'h0C: cfg1_v <= bus_wdata;
            8'h14: cfg3_v <= bus_wdata;
            8'h10: begin
              reg_cfg2 <= bus_wdata;
              cfg2_wr_n <= cfg2_wr_n + 1;
              if (cfg2_wr_n == 0) cfg2a_v <= bus_wdata;
              else begin cfg2b_v <= bus_wdata; lock_at_en <= lock_bit; end
            end
            8'h08: if (bus_wdata[0]) begin
              go_bit <= 1'b1; lock_bit <= 1'b0; go_t <= 0; go_run <= 1'b1;
              commit_n <= commit_n + 1;
            end
            default: ;
          endcase
        end else begin
          case (bus_addr)
            8'h08: bus_rdata <= {31'b0, go_bit};
            8'h10: bus_rdata <= reg_cfg2;
            8'h04: begin
              st = 32'h1 | (32'(lock_bit) << 1);
              if (cfg2_wr_n >= 2) begin
                ack_rd <= ack_rd + 1;
                if (ack_rd + 1 >= ack_k)
                  st = st | (32'(reg_cfg2[16]) << 7) | (32'(reg_cfg2[18]) << 8) |
                            (32'(reg_cfg2[23]) << 10) | (32'(reg_cfg2[25]) << 11);
              end else if (go_run) lock_rd <= lock_rd + 1;
              bus_rdata <= st;
            end
            default: bus_rdata <= '0;
          endcase
        end
      end
    end
  end

  // ---------------- expected-value helpers ----------------
  function automatic logic [31:0] enc(input logic [4:0] v);
    return (v == 0) ? 32'd0 : 32'(v) - 32'd1;
  endfunction

  function automatic logic [31:0] exp_cfg1(input logic [7:0] n, input logic [11:0] m,
                                           input logic [19:0] d);
    return ((32'(n) - 32'd1) << 1) | (32'(m) << 9) | (enc(d[4:0]) << 21) |
           (enc(d[9:5]) << 26);
  endfunction

  function automatic logic [31:0] exp_cfg3(input logic [19:0] d);
    return enc(d[14:10]) | (enc(d[19:15]) << 5);
  endfunction

  function automatic logic [31:0] exp_pre(input logic [31:0] init, input logic [2:0] sel);
    logic [31:0] v;
    v = (init & ~(32'hF << 1)) | (32'(sel) << 1);
    v = v | (32'd1 << 13) | (32'd1 << 20);
    v = v & ~((32'd1 << 14) | (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 23) | (32'd1 << 25));
    return v;
  endfunction

  function automatic logic [31:0] exp_en(input logic [31:0] pre, input logic [19:0] d);
    logic [31:0] v;
    v = (pre | (32'd1 << 14)) & ~(32'd1 << 20);
    if (d[4:0]   != 0) v = v | (32'd1 << 16);
    if (d[9:5]   != 0) v = v | (32'd1 << 18);
    if (d[14:10] != 0) v = v | (32'd1 << 23);
    if (d[19:15] != 0) v = v | (32'd1 << 25);
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [7:0] n, input logic [11:0] m, input logic [19:0] d,
                          input logic [15:0] f, input int gd, input int ld, input int ak,
                          input int extra_start);
    int cyc;
    n_in = n; m_in = m; d_in = d; f_in = f;
    go_delay = gd; lock_delay = ld; ack_k = ak;
    cfg2_init = 32'hC001_4201;
    model_clr = 1'b1;
    @(negedge clk);
    model_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 20000) begin
      if (cyc == extra_start) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 20000) chk("R11", "watchdog run ended", 32'd0, 32'd1);
  endtask

  // vector: n[58:51] m[50:39] d7..d4[38:19] fint[18:3] sel[2:0]
  localparam logic [58:0] VEC [6] = '{
    {8'd10,  12'd300,  5'd7,  5'd0,  5'd5,  5'd4,  16'd999,  3'd3},
    {8'd1,   12'd1,    5'd0,  5'd0,  5'd0,  5'd1,  16'd1000, 3'd4},
    {8'd255, 12'd4095, 5'd31, 5'd31, 5'd31, 5'd31, 16'd1250, 3'd5},
    {8'd3,   12'd100,  5'd0,  5'd0,  5'd0,  5'd0,  16'd1749, 3'd6},
    {8'd7,   12'd2047, 5'd0,  5'd16, 5'd2,  5'd0,  16'd1750, 3'd7},
    {8'd2,   12'd50,   5'd1,  5'd3,  5'd0,  5'd9,  16'd1500, 3'd6}
  };

  initial begin
    go_delay = 5; lock_delay = 10; ack_k = 3; cfg2_init = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "req after reset", {31'b0, bus_req}, 32'd0);
    chk("R11", "busy after reset", {31'b0, busy}, 32'd0);
    chk("R11", "done/err after reset", {30'b0, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] pre;
      run_case(VEC[i][58:51], VEC[i][50:39], VEC[i][38:19], VEC[i][18:3], 5, 10, 3, -1);
      pre = exp_pre(32'hC001_4201, VEC[i][2:0]);
      chk("R8", "done", {30'b0, done, err}, 32'd2);
      chk("R11", "code on success", {30'b0, code}, 32'd0);
      chk("R1", "cfg1 word", cfg1_v, exp_cfg1(VEC[i][58:51], VEC[i][50:39], VEC[i][38:19]));
      chk("R2", "cfg3 word", cfg3_v, exp_cfg3(VEC[i][38:19]));
      chk("R3", "range field", {28'b0, cfg2a_v[4:1]}, {29'b0, VEC[i][2:0]});
      chk("R4", "first cfg2", cfg2a_v, pre);
      chk("R5", "write count", wr_n, 5);
      chk("R5", "write order", {wr_log[0], wr_log[1], wr_log[2], wr_log[3]}, 32'h0C141008);
      chk("R6", "lock before enable", {31'b0, lock_at_en}, 32'd1);
      chk("R7", "second cfg2", cfg2b_v, exp_en(pre, VEC[i][38:19]));
    end

    // R8 acknowledge on the 100th read still succeeds; start while busy ignored (R11)
    run_case(8'd4, 12'd200, {5'd2, 5'd2, 5'd2, 5'd2}, 16'd1100, 5, 10, 100, 30);
    chk("R8", "ack on last read", {30'b0, done, err}, 32'd2);
    chk("R8", "ack reads used", ack_rd, 100);
    chk("R11", "busy start ignored", commit_n, 1);

    // R8 acknowledge one read late -> code 3
    run_case(8'd4, 12'd200, {5'd2, 5'd2, 5'd2, 5'd2}, 16'd1100, 5, 10, 101, -1);
    chk("R8", "ack timeout", {29'b0, err, code}, {29'b0, 1'b1, 2'd3});
    chk("R8", "ack reads at give-up", ack_rd, 100);

    // R8 no outputs requested: first read completes
    run_case(8'd4, 12'd200, 20'd0, 16'd1100, 5, 10, 1000, -1);
    chk("R8", "empty mask done", {30'b0, done, err}, 32'd2);

    // R9 commit bit stuck
    run_case(8'd4, 12'd200, 20'd3, 16'd1100, -1, 10, 3, -1);
    chk("R9", "commit stuck code", {29'b0, err, code}, {29'b0, 1'b1, 2'd1});
    chk("R9", "no enable write after commit error", cfg2_wr_n, 1);
    chk("R9", "commit timeout not early", {31'b0, go_t >= 2000}, 32'd1);

    // R9 lock never arrives
    run_case(8'd4, 12'd200, 20'd3, 16'd1100, 5, -1, 3, -1);
    chk("R9", "no lock code", {29'b0, err, code}, {29'b0, 1'b1, 2'd2});
    chk("R9", "no enable write after lock error", cfg2_wr_n, 1);
    chk("R9", "lock timeout window", {31'b0, go_t >= 2000 && go_t < 2200}, 32'd1);

    // R9 late lock caught by slow polling
    run_case(8'd4, 12'd200, 20'd3, 16'd1100, 5, 600, 3, -1);
    chk("R9", "late lock done", {30'b0, done, err}, 32'd2);
    chk("R9", "slow poll read count", {31'b0, lock_rd > 100 && lock_rd < 130}, 32'd1);

    // R11 result held in idle
    repeat (5) @(negedge clk);
    chk("R11", "done held", {30'b0, done, err}, 32'd2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule